// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block turns a stream of stereo PCM sample pairs into a three-wire serial audio bus made of a bit clock, a word clock and a data line. A 4-bit mode code picks one of eleven formats. Each format fixes three things: the frame rate (1x, 2x or 4x the base sample rate), the word length (16 or 18 bits) and the justification (I2S-style, with the word one bit late and aligned to the front of the slot, or EIAJ-style, aligned to the back of the slot). Each frame is 48 bit clocks long and holds two 24-bit channel slots. The bit clock comes from a master tick enable. At the 4x rate one half-period of the bit clock lasts `HALF_TICKS` ticks. The 2x rate doubles that and the 1x rate quadruples it.

A new sample pair is taken once per frame through a valid/ready handshake. If no pair is offered, the previous pair is sent again and an underrun flag is raised for that frame. The word-clock polarity and the data polarity can each be inverted. In the 1x formats an error-flag line carries a per-pair flag. The block also reports whether the active format is one of the interpolated formats or one of the two raw pass-through formats. Mode, polarity and processing-state changes take effect only at a frame boundary.

Top module: `audio_serial_formatter`

## Requirements
- R1: Mode codes map as follows. 1x rate: 1010 (I2S, 16 bits, raw), 1011 (EIAJ, 16 bits, raw), 1110 (I2S, 16 or 18 bits), 0010 (EIAJ, 16 bits), 0110 (EIAJ, 18 bits). 2x rate: 0011 (EIAJ, 16 bits), 0111 (EIAJ, 18 bits), 1111 (I2S, 18 bits). 4x rate: 0000 (EIAJ, 16 bits), 0100 (EIAJ, 18 bits), 1100 (I2S, 18 bits). Bit positions 0..23 of a frame form the left slot, with `wclk` low before inversion. Positions 24..47 form the right slot, with `wclk` high.
- R2: Each half-period of `bclk` lasts HALF_TICKS×1 `tick_en` ticks at the 4x rate, ×2 at the 2x rate and ×4 at the 1x rate. A frame lasts 48 `bclk` periods.
- R3: The word is the top W bits of the 18-bit sample (W = 16 or 18), and it is sent MSB first.
- R4: In I2S-style framing the word MSB is at slot position 1, and every slot bit after the word is 0.
- R5: In EIAJ-style framing the word LSB is at slot position 23, and every slot bit before the word is 0.
- R6: `sdata` and `wclk` change only on a falling edge of `bclk`, so both are stable while `bclk` is high.
- R7: `inv_wclk` inverts `wclk` and `inv_data` inverts `sdata`. Both are sampled at the frame boundary and hold for the whole frame.
- R8: In mode 1110 the word is 16 bits, or 18 bits when `proc_active` is high at the frame boundary.
- R9: In 1x-rate modes `eflag` carries the `smp_err` of the pair being sent; in other modes it is 0. `interp` is 0 in modes 1010 and 1011 and 1 in every other mode.
- R10: `smp_ready` pulses for one cycle per frame, in the cycle before the `bclk` falling edge that starts the frame. The pair is taken when `smp_valid` is high in that cycle.
- R11: If `smp_valid` is low at the boundary, the previous pair and its error flag are sent again and `underrun` is 1 for that frame. `underrun` is 0 in a frame whose pair was accepted.
- R12: A new `mode_code` takes effect only at a frame boundary. An unlisted code (0001, 0101, 1000, 1001, 1101) is ignored and the previous mode is kept.
- R13: In reset `bclk` is 1 and `wclk`, `sdata`, `eflag`, `underrun`, `smp_ready` and `interp` are 0. The mode is 1010, and the first frame starts at the first `bclk` falling edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Master clock enable that paces the bit clock |
| mode_code | input | 4 | Format selection code |
| inv_wclk | input | 1 | Invert the word clock |
| inv_data | input | 1 | Invert the data line |
| proc_active | input | 1 | Processing active; widens mode 1110 to 18 bits |
| smp_valid | input | 1 | A sample pair is offered |
| smp_left | input | SAMPLE_W | Left sample, MSB-aligned |
| smp_right | input | SAMPLE_W | Right sample, MSB-aligned |
| smp_err | input | 1 | Error flag of the offered pair |
| smp_ready | output | 1 | Pair accepted this cycle if valid |
| bclk | output | 1 | Serial bit clock |
| wclk | output | 1 | Serial word clock |
| sdata | output | 1 | Serial data |
| eflag | output | 1 | Error flag line |
| underrun | output | 1 | Current frame repeats the previous pair |
| interp | output | 1 | Active format is an interpolated one |

## Verification
The bench rebuilds every frame from the `bclk` rising edges and compares it bit by bit with a frame it computes from the accepted pair. A design with the wrong justification, an off-by-one start bit or a swapped channel therefore fails at a specific bit position. Mode changes, unlisted codes and mid-frame changes to `proc_active` and the polarity controls are applied in the middle of a frame. A design that switches early corrupts the tail of the current frame, and a design that accepts an unlisted code changes the framing. The bench withholds `smp_valid` to force underruns, which exposes designs that send zeros or do not flag the repeat. It also measures each half-period of `bclk` against the tick count under a gapped `tick_en`, which catches a divider that uses the wrong rate or lets the rate change mid-frame.

// File: rtl/asf_pkg.sv
package asf_pkg;

   typedef enum logic [1:0] {
      RATE_1X = 2'd0,
      RATE_2X = 2'd1,
      RATE_4X = 2'd2
   } rate_e;

   typedef struct packed {
      logic  legal;
      rate_e rate;
      logic  i2s;
      logic  wide;
      logic  adaptive;
      logic  raw;
   } fmt_t;

   // Format table: rate, justification, width, adaptive width, raw pass-through
   function automatic fmt_t decode_code(input logic [3:0] c);
      fmt_t f;
      f = '{legal: 1'b1, rate: RATE_1X, i2s: 1'b0, wide: 1'b0, adaptive: 1'b0, raw: 1'b0};
      case (c)
         4'b1010: begin f.i2s = 1'b1; f.raw = 1'b1; end
         4'b1011: f.raw = 1'b1;
         4'b1110: begin f.i2s = 1'b1; f.adaptive = 1'b1; end
         4'b0010: ;
         4'b0110: f.wide = 1'b1;
         4'b0000: f.rate = RATE_4X;
         4'b0100: begin f.rate = RATE_4X; f.wide = 1'b1; end
         4'b1100: begin f.rate = RATE_4X; f.wide = 1'b1; f.i2s = 1'b1; end
         4'b0011: f.rate = RATE_2X;
         4'b0111: begin f.rate = RATE_2X; f.wide = 1'b1; end
         4'b1111: begin f.rate = RATE_2X; f.wide = 1'b1; f.i2s = 1'b1; end
         default: f.legal = 1'b0;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/asf_bit_timer.sv
module asf_bit_timer
   import asf_pkg::*;
#(
   parameter int HALF_TICKS = 1,
   parameter int FRAME_BITS = 48,
   localparam int IDX_W = $clog2(FRAME_BITS),
   localparam int CNT_W = $clog2(4 * HALF_TICKS) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  rate_e            rate,
   output logic             bclk,
   output logic [IDX_W-1:0] bidx,
   output logic [IDX_W-1:0] bidx_nxt,
   output logic             fall_now,
   output logic             frame_start
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

   logic [CNT_W-1:0] hcnt;
   logic [CNT_W-1:0] div_m1;
   logic             edge_now;

   always_comb begin
      case (rate)
         RATE_4X: div_m1 = CNT_W'(HALF_TICKS - 1);
         RATE_2X: div_m1 = CNT_W'(2 * HALF_TICKS - 1);
         default: div_m1 = CNT_W'(4 * HALF_TICKS - 1);
      endcase
   end

   assign edge_now    = tick_en && (hcnt >= div_m1);
   assign fall_now    = edge_now && bclk;
   assign frame_start = fall_now && (bidx == LAST_IDX);
   assign bidx_nxt    = (bidx == LAST_IDX) ? '0 : bidx + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt <= '0;
         bclk <= 1'b1;
         bidx <= LAST_IDX;
      end else if (tick_en) begin
         if (edge_now) begin
            hcnt <= '0;
            bclk <= ~bclk;
            if (fall_now) bidx <= bidx_nxt;
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end

   // R2: bit index never leaves the frame
   a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      bidx <= LAST_IDX);
   // R6: the bit index only advances on a falling bclk edge
   a_r6_idx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bidx) |-> $fell(bclk));

endmodule

// File: rtl/asf_slot_bit.sv
module asf_slot_bit #(
   parameter int SLOT_BITS = 24,
   parameter int SAMPLE_W  = 18,
   localparam int IDX_W = $clog2(2 * SLOT_BITS)
) (
   input  logic [IDX_W-1:0]    pos,
   input  logic [SAMPLE_W-1:0] left,
   input  logic [SAMPLE_W-1:0] right,
   input  logic                is_i2s,
   input  logic                wide,
   output logic                bit_o,
   output logic                right_sel
);

   always_comb begin
      int p, k, wlen;
      logic [SAMPLE_W-1:0] s;
      logic [SAMPLE_W-1:0] sh;
      sh        = '0;
      right_sel = (pos >= IDX_W'(SLOT_BITS));
      p         = right_sel ? int'(pos) - SLOT_BITS : int'(pos);
      wlen      = wide ? 18 : 16;
      s         = right_sel ? right : left;
      k         = is_i2s ? p - 1 : p - (SLOT_BITS - wlen);
      bit_o     = 1'b0;
      if (k >= 0 && k < wlen) begin
         sh    = s >> (SAMPLE_W - 1 - k);
         bit_o = sh[0];
      end
   end

endmodule

// File: rtl/audio_serial_formatter.sv
module audio_serial_formatter
   import asf_pkg::*;
#(
   parameter int SAMPLE_W   = 18,
   parameter int SLOT_BITS  = 24,
   parameter int HALF_TICKS = 1,
   localparam int FRAME_BITS = 2 * SLOT_BITS,
   localparam int IDX_W = $clog2(FRAME_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic [3:0]          mode_code,
   input  logic                inv_wclk,
   input  logic                inv_data,
   input  logic                proc_active,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   input  logic                smp_err,
   output logic                smp_ready,
   output logic                bclk,
   output logic                wclk,
   output logic                sdata,
   output logic                eflag,
   output logic                underrun,
   output logic                interp
);

   if (SAMPLE_W < 18) begin : g_bad_sample_w
      $error("SAMPLE_W must hold an 18-bit word");
   end
   if (SLOT_BITS < 19) begin : g_bad_slot
      $error("SLOT_BITS must exceed the longest word plus one");
   end
   if (HALF_TICKS < 1) begin : g_bad_ticks
      $error("HALF_TICKS must be at least 1");
   end

   // frame-level state
   logic [3:0]          cur_code;
   logic [SAMPLE_W-1:0] cur_l, cur_r;
   logic                cur_err, cur_invw, cur_invd, cur_wide;
   fmt_t                cur_fmt;

   // values in force for the bit being launched
   logic [3:0]          n_code;
   fmt_t                n_fmt;
   logic [SAMPLE_W-1:0] n_l, n_r;
   logic                n_err, n_invw, n_invd, n_wide;

   logic [IDX_W-1:0]    bidx, bidx_nxt;
   logic                fall_now, frame_start;
   logic                slot_bit, right_sel;
   logic                wclk_q, sdata_q, eflag_q, under_q;

   assign cur_fmt = decode_code(cur_code);

   asf_bit_timer #(.HALF_TICKS(HALF_TICKS), .FRAME_BITS(FRAME_BITS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate(cur_fmt.rate),
      .bclk(bclk), .bidx(bidx), .bidx_nxt(bidx_nxt),
      .fall_now(fall_now), .frame_start(frame_start)
   );

   always_comb begin
      fmt_t in_fmt;
      in_fmt = decode_code(mode_code);
      if (frame_start) begin
         n_code = in_fmt.legal ? mode_code : cur_code;
         n_l    = smp_valid ? smp_left  : cur_l;
         n_r    = smp_valid ? smp_right : cur_r;
         n_err  = smp_valid ? smp_err   : cur_err;
         n_invw = inv_wclk;
         n_invd = inv_data;
      end else begin
         n_code = cur_code;
         n_l    = cur_l;
         n_r    = cur_r;
         n_err  = cur_err;
         n_invw = cur_invw;
         n_invd = cur_invd;
      end
      n_fmt  = decode_code(n_code);
      n_wide = frame_start ? (n_fmt.wide | (n_fmt.adaptive & proc_active)) : cur_wide;
   end

   asf_slot_bit #(.SLOT_BITS(SLOT_BITS), .SAMPLE_W(SAMPLE_W)) u_slot (
      .pos(bidx_nxt), .left(n_l), .right(n_r), .is_i2s(n_fmt.i2s),
      .wide(n_wide), .bit_o(slot_bit), .right_sel(right_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_code <= 4'b1010;
         cur_l    <= '0;
         cur_r    <= '0;
         cur_err  <= 1'b0;
         cur_invw <= 1'b0;
         cur_invd <= 1'b0;
         cur_wide <= 1'b0;
         wclk_q   <= 1'b0;
         sdata_q  <= 1'b0;
         eflag_q  <= 1'b0;
         under_q  <= 1'b0;
      end else begin
         if (frame_start) begin
            cur_code <= n_code;
            cur_l    <= n_l;
            cur_r    <= n_r;
            cur_err  <= n_err;
            cur_invw <= n_invw;
            cur_invd <= n_invd;
            cur_wide <= n_wide;
            eflag_q  <= (n_fmt.rate == RATE_1X) & n_err;
            under_q  <= ~smp_valid;
         end
         if (fall_now) begin
            sdata_q <= slot_bit ^ n_invd;
            wclk_q  <= right_sel ^ n_invw;
         end
      end
   end

   assign smp_ready = frame_start;
   assign wclk      = wclk_q;
   assign sdata     = sdata_q;
   assign eflag     = eflag_q;
   assign underrun  = under_q;
   assign interp    = ~cur_fmt.raw;

   // R10: a request is followed by the first falling edge of a frame
   a_r10_ready_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
      smp_ready |=> ($fell(bclk) && bidx == '0));
   // R6: data holds while bclk is high
   a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (bclk && $past(bclk)) |-> $stable(sdata));
   // R6: word clock moves only with a falling bclk edge
   a_r6_wclk_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wclk) |-> $fell(bclk));
   // R9: error line idle outside the 1x modes
   a_r9_eflag_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_fmt.rate != RATE_1X) |-> !eflag);
   // R12: the mode in force is always a listed code
   a_r12_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cur_fmt.legal);
   // R11: a refused request keeps the held pair
   a_r11_repeat_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_ready && !smp_valid) |=> ($stable(cur_l) && $stable(cur_r) && underrun));

endmodule

// File: tb/audio_serial_formatter_test.sv
`timescale 1ns/1ps
module audio_serial_formatter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic [3:0]  mode_code = 4'b1010;
   logic        inv_wclk = 1'b0, inv_data = 1'b0, proc_active = 1'b0;
   logic        smp_valid = 1'b0, smp_err = 1'b0;
   logic [17:0] smp_left = '0, smp_right = '0;
   logic        smp_ready, bclk, wclk, sdata, eflag, underrun, interp;

   int checks = 0, errors = 0, cyc = 0;
   bit gap_en = 0, vrand = 0, starve = 0, done = 0;

   audio_serial_formatter uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_code(mode_code),
      .inv_wclk(inv_wclk), .inv_data(inv_data), .proc_active(proc_active),
      .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
      .smp_err(smp_err), .smp_ready(smp_ready), .bclk(bclk), .wclk(wclk),
      .sdata(sdata), .eflag(eflag), .underrun(underrun), .interp(interp)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // reference format table
   function automatic bit code_ok(input logic [3:0] m);
      return m inside {4'b1010, 4'b1011, 4'b1110, 4'b0010, 4'b0110, 4'b0000,
                       4'b0100, 4'b1100, 4'b0011, 4'b0111, 4'b1111};
   endfunction
   function automatic int half_ticks(input logic [3:0] m);
      if (m inside {4'b0000, 4'b0100, 4'b1100}) return 1;
      if (m inside {4'b0011, 4'b0111, 4'b1111}) return 2;
      return 4;
   endfunction
   function automatic bit is_i2s(input logic [3:0] m);
      return m inside {4'b1010, 4'b1110, 4'b1100, 4'b1111};
   endfunction
   function automatic int word_len(input logic [3:0] m, input bit pr);
      if (m == 4'b1110) return pr ? 18 : 16;
      return (m inside {4'b0110, 4'b0100, 4'b1100, 4'b0111, 4'b1111}) ? 18 : 16;
   endfunction
   function automatic bit exp_bit(input logic [3:0] m, input bit pr,
                                  input logic [17:0] l, input logic [17:0] r, input int pos);
      int w, slot, first;
      logic [17:0] s;
      w     = word_len(m, pr);
      s     = (pos >= 24) ? r : l;
      slot  = pos % 24;
      first = is_i2s(m) ? 1 : 24 - w;
      if (slot < first || slot >= first + w) return 1'b0;
      return s[17 - (slot - first)];
   endfunction

   // stimulus driver, away from the active edge
   always @(posedge clk) begin
      #1;
      tick_en   <= gap_en ? (($urandom % 4) != 0) : 1'b1;
      smp_left  <= 18'($urandom);
      smp_right <= 18'($urandom);
      smp_err   <= 1'($urandom);
      smp_valid <= starve ? 1'b0 : (vrand ? (($urandom % 6) != 0) : 1'b1);
   end

   // monitor state
   bit          prev_bclk = 1, prev_en = 1, in_frame = 0, held_d, held_w;
   int          pos = 0, tcnt = 0;
   logic [3:0]  emode = 4'b1010;
   logic [17:0] el = '0, er = '0;
   bit          eerr = 0, eunder = 0, einvw = 0, einvd = 0, epr = 0, illegal_seen = 0;

   always @(negedge clk) begin
      cyc++;
      if (!done && cyc > 150000) begin
         chk(0, "watchdog expired", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
      if (!rst_n) begin
         prev_bclk = 1; tcnt = 0; in_frame = 0;
      end else begin
         tcnt += int'(prev_en);
         if (bclk != prev_bclk) begin
            if (bclk && in_frame && pos < 48) begin
               string dt;
               chk(tcnt == half_ticks(emode), "R2 bclk half period", tcnt, half_ticks(emode));
               dt = (emode == 4'b1110) ? "R8 R3" : (is_i2s(emode) ? "R4 R3" : "R5 R3");
               if (einvd) dt = {dt, " R7"};
               if (illegal_seen) dt = {dt, " R12"};
               chk(sdata == (exp_bit(emode, epr, el, er, pos) ^ einvd),
                   $sformatf("%s data bit %0d mode %b", dt, pos, emode),
                   int'(sdata), int'(exp_bit(emode, epr, el, er, pos) ^ einvd));
               chk(wclk == ((pos >= 24) ^ einvw), $sformatf("R1 R7 word clock bit %0d", pos),
                   int'(wclk), int'((pos >= 24) ^ einvw));
               chk(eflag == ((half_ticks(emode) == 4) & eerr), "R9 eflag", int'(eflag),
                   int'((half_ticks(emode) == 4) & eerr));
               chk(interp == !(emode inside {4'b1010, 4'b1011}), "R9 R12 interp flag",
                   int'(interp), int'(!(emode inside {4'b1010, 4'b1011})));
               chk(underrun == eunder, "R11 underrun flag", int'(underrun), int'(eunder));
               held_d = sdata; held_w = wclk;
               pos++;
            end
            tcnt = 0;
         end else if (bclk && in_frame && pos > 0) begin
            chk(sdata == held_d && wclk == held_w, "R6 lines stable while bclk high",
                int'({sdata, wclk}), int'({held_d, held_w}));
         end
         prev_bclk = bclk;
         if (smp_ready) begin
            chk(bclk == 1'b1, "R10 request before falling edge", int'(bclk), 1);
            if (in_frame) chk(pos == 48, "R10 one request per 48-bit frame", pos, 48);
            if (code_ok(mode_code)) emode = mode_code;
            if (smp_valid) begin el = smp_left; er = smp_right; eerr = smp_err; end
            eunder = !smp_valid;
            einvw = inv_wclk; einvd = inv_data; epr = proc_active;
            in_frame = 1; pos = 0;
         end
      end
      prev_en = tick_en;
   end

   task automatic wait_frames(input int n);
      repeat (n) begin
         do @(negedge clk); while (!smp_ready);
      end
      @(posedge clk); #2;
   endtask

   task automatic mid_frame();
      repeat (20) @(posedge clk);
      #2;
   endtask

   initial begin
      logic [3:0] codes[11] = '{4'b1010, 4'b1011, 4'b1110, 4'b0010, 4'b0110, 4'b0000,
                                4'b0100, 4'b1100, 4'b0011, 4'b0111, 4'b1111};
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R13: reset state
      chk(bclk == 1'b1, "R13 reset bclk", int'(bclk), 1);
      chk(wclk == 1'b0 && sdata == 1'b0, "R13 reset wclk/sdata", int'({wclk, sdata}), 0);
      chk(eflag == 1'b0 && underrun == 1'b0, "R13 reset eflag/underrun", int'({eflag, underrun}), 0);
      chk(smp_ready == 1'b0 && interp == 1'b0, "R13 reset ready/interp", int'({smp_ready, interp}), 0);
      @(posedge clk); #2; rst_n = 1'b1;
      wait_frames(2);
      // R1 R3 R4 R5: every listed format, changed mid-frame (R12 timing)
      foreach (codes[i]) begin
         mid_frame();
         mode_code = codes[i];
         wait_frames(3);
      end
      // R8: adaptive width
      mode_code = 4'b1110; wait_frames(2);
      mid_frame(); proc_active = 1'b1; wait_frames(2);
      mid_frame(); proc_active = 1'b0; wait_frames(2);
      // R7: polarity inversion
      mid_frame(); inv_wclk = 1'b1; wait_frames(2);
      mid_frame(); inv_data = 1'b1; mode_code = 4'b0100; wait_frames(2);
      mid_frame(); inv_wclk = 1'b0; wait_frames(2);
      inv_data = 1'b0;
      // R11: starvation
      mode_code = 4'b0010; wait_frames(1);
      starve = 1; wait_frames(3);
      starve = 0; wait_frames(2);
      // R12: unlisted codes are ignored
      mode_code = 4'b1011; wait_frames(2);
      illegal_seen = 1;
      mode_code = 4'b0101; wait_frames(2);
      mode_code = 4'b1101; wait_frames(2);
      illegal_seen = 0;
      // random mix with gapped ticks
      gap_en = 1; vrand = 1;
      for (int n = 0; n < 50; n++) begin
         mid_frame();
         if (($urandom % 3) == 0) mode_code = 4'($urandom);
         illegal_seen = !code_ok(mode_code);
         inv_wclk = 1'($urandom);
         inv_data = 1'($urandom);
         proc_active = 1'($urandom);
         wait_frames(1);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule